// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Slice

This block models one output slice of a programmable logic array. A connection map picks, for each product term, which array inputs take part and in which polarity. Every array input is offered both as itself and as its inverse. Eight data product terms are ORed together to form the slice's sum. A ninth product term serves only as an output-enable term. The sum then enters an output cell. That cell either stores the sum in a flip-flop or passes it straight through. It applies a programmable output polarity and decides whether the pin driver is on. It also picks the value that is routed back into the array as the feedback input.

Three configuration bits choose the operating mode. Two of them are global, shared by every slice of a device, and one is local to this slice. The modes are registered output, combinatorial output, combinatorial bidirectional I/O, and dedicated input. The flip-flop clears on reset. A test preload can load it with any value, and the preload wins over normal capture. The pin is modelled as separate signals: an output value, a drive enable and a sensed input value. The array input vector is the external inputs with the feedback bit placed above them, at index N_EXT.

Top module: `sop_slice`

## Requirements
- R1: A product term with no fuse set (nothing connected) evaluates to 1.
- R2: A product term that connects both the true and the complement literal of the same input evaluates to 0 for every input value.
- R3: Fuse layout: term t uses fuse bits [t*2*N_ARR +: 2*N_ARR]. Within that field, bit 2k connects array input k true and bit 2k+1 connects it complemented. A term is the AND of its connected literals.
- R4: The sum is the OR of data terms 0..N_TERM-1 only. Term N_TERM is the enable term and never contributes to the sum.
- R5: Mode decode from {cfg_simple_i, cfg_regfam_i, cfg_local_i}:
  - 1x0 selects combinatorial output.
  - 1x1 selects dedicated input.
  - 010 selects registered output.
  - 011 selects combinatorial I/O.
  - 00x selects combinatorial I/O.
- R6: In registered mode the flip-flop captures the sum on the rising clock edge. pad_o shows the flip-flop value when pol_i=1 and its inverse when pol_i=0. The driver is on exactly when oe_ni is 0.
- R7: In combinatorial output mode, pad_o is the sum when pol_i=1 and its inverse when pol_i=0. pad_oe_o is always 1.
- R8: In combinatorial I/O mode, pad_oe_o equals the enable term and fb_o equals pad_i.
- R9: In dedicated-input mode, pad_oe_o is always 0 and fb_o equals pad_i.
- R10: In registered mode, fb_o is the inverse of the flip-flop value.
- R11: While rst_ni is 0 the flip-flop holds 0. In registered mode with pol_i=1, pad_o is then 0.
- R12: When pre_en_i is 1 at a rising clock edge, the flip-flop loads pre_val_i instead of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global register clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| in_i | input | N_EXT | External array inputs |
| fuse_i | input | (N_TERM+1)*2*N_ARR | Connection map, one field per term |
| cfg_simple_i | input | 1 | Global mode bit A |
| cfg_regfam_i | input | 1 | Global mode bit B |
| cfg_local_i | input | 1 | Local mode bit of this slice |
| pol_i | input | 1 | Output polarity, 1 = active-high |
| oe_ni | input | 1 | Global active-low output enable for registered mode |
| pre_en_i | input | 1 | Register preload request |
| pre_val_i | input | 1 | Register preload value |
| pad_i | input | 1 | Value sensed on the pin |
| pad_o | output | 1 | Value driven to the pin |
| pad_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback value into the array (input index N_EXT) |

## Verification
The hardest case to reach is a clock edge where a preload and a differing sum arrive together. Only then does the preload priority show at the pin. The bench sets up a map whose sum is known to be 1 and requests a preload of 0 on the same edge, then does the reverse. Registered feedback is also hard to see, because it only reaches the pin through the array. The bench therefore checks fb_o directly after known captures, and it also builds a term from the feedback literal.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    MD_REG   = 2'd0,
    MD_COMB  = 2'd1,
    MD_BIDIR = 2'd2,
    MD_INPUT = 2'd3
  } slice_mode_e;

  // One literal passes when it is unconnected or its condition holds.
  function automatic logic lit_pass(input logic val, input logic use_true,
                                    input logic use_comp);
    return (~use_true | val) & (~use_comp | ~val);
  endfunction

  // Global A, global B, local C to mode.
  function automatic slice_mode_e decode_mode(input logic ga, input logic gb,
                                              input logic lc);
    slice_mode_e m;
    if (ga) begin
      m = lc ? MD_INPUT : MD_COMB;
    end else if (gb) begin
      m = lc ? MD_BIDIR : MD_REG;
    end else begin
      m = MD_BIDIR;
    end
    return m;
  endfunction

  function automatic logic apply_pol(input logic v, input logic active_high);
    return active_high ? v : ~v;
  endfunction

endpackage

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_ARR = 5
) (
  input  logic [N_ARR-1:0]   arr_i,
  input  logic [2*N_ARR-1:0] fuse_i,
  output logic               term_o
);
  import sop_pkg::*;

  logic [N_ARR-1:0] pass_w;

  for (genvar k = 0; k < N_ARR; k++) begin : g_lit
    assign pass_w[k] = lit_pass(arr_i[k], fuse_i[2*k], fuse_i[2*k+1]);
  end

  assign term_o = &pass_w;
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_ARR  = 5,
  parameter int N_TERM = 8,
  localparam int FW    = 2 * N_ARR,
  localparam int NT    = N_TERM + 1
) (
  input  logic [N_ARR-1:0] arr_i,
  input  logic [NT*FW-1:0] fuse_i,
  output logic [NT-1:0]    terms_o,
  output logic             sum_o,
  output logic             en_term_o
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    sop_term #(.N_ARR(N_ARR)) u_term (
      .arr_i  (arr_i),
      .fuse_i (fuse_i[t*FW +: FW]),
      .term_o (terms_o[t])
    );
  end

  assign sum_o     = |terms_o[N_TERM-1:0];
  assign en_term_o = terms_o[N_TERM];
endmodule

// File: rtl/sop_cell.sv
module sop_cell
  import sop_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  slice_mode_e mode_i,
  input  logic        sum_i,
  input  logic        en_term_i,
  input  logic        pol_i,
  input  logic        oe_ni,
  input  logic        pre_en_i,
  input  logic        pre_val_i,
  input  logic        pad_i,
  output logic        q_o,
  output logic        pad_o,
  output logic        pad_oe_o,
  output logic        fb_o
);
  logic q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= 1'b0;
    end else if (pre_en_i) begin
      q_r <= pre_val_i;
    end else begin
      q_r <= sum_i;
    end
  end

  assign q_o = q_r;

  always_comb begin
    pad_o = apply_pol(sum_i, pol_i);
    pad_oe_o = 1'b0;
    fb_o = pad_i;
    unique case (mode_i)
      MD_REG: begin
        pad_o    = apply_pol(q_r, pol_i);
        pad_oe_o = ~oe_ni;
        fb_o     = ~q_r;
      end
      MD_COMB:  pad_oe_o = 1'b1;
      MD_BIDIR: pad_oe_o = en_term_i;
      MD_INPUT: pad_oe_o = 1'b0;
      default:  pad_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sop_slice.sv
module sop_slice
  import sop_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int N_TERM = 8,
  localparam int N_ARR = N_EXT + 1,
  localparam int FW    = 2 * N_ARR,
  localparam int NT    = N_TERM + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] in_i,
  input  logic [NT*FW-1:0] fuse_i,
  input  logic             cfg_simple_i,
  input  logic             cfg_regfam_i,
  input  logic             cfg_local_i,
  input  logic             pol_i,
  input  logic             oe_ni,
  input  logic             pre_en_i,
  input  logic             pre_val_i,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic             fb_o
);
  slice_mode_e      mode_w;
  logic [N_ARR-1:0] arr_w;
  logic [NT-1:0]    terms_w;
  logic             sum_w;
  logic             en_term_w;
  logic             q_w;
  logic             fb_w;

  assign mode_w = decode_mode(cfg_simple_i, cfg_regfam_i, cfg_local_i);
  assign arr_w  = {fb_w, in_i};

  sop_array #(.N_ARR(N_ARR), .N_TERM(N_TERM)) u_array (
    .arr_i     (arr_w),
    .fuse_i    (fuse_i),
    .terms_o   (terms_w),
    .sum_o     (sum_w),
    .en_term_o (en_term_w)
  );

  sop_cell u_cell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_w),
    .sum_i     (sum_w),
    .en_term_i (en_term_w),
    .pol_i     (pol_i),
    .oe_ni     (oe_ni),
    .pre_en_i  (pre_en_i),
    .pre_val_i (pre_val_i),
    .pad_i     (pad_i),
    .q_o       (q_w),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o),
    .fb_o      (fb_w)
  );

  assign fb_o = fb_w;
endmodule

// File: rtl/sop_slice_chk.sv
module sop_slice_chk
  import sop_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input slice_mode_e mode_w,
  input logic        sum_w,
  input logic        en_term_w,
  input logic        q_w,
  input logic        pre_en_i,
  input logic        pre_val_i,
  input logic        oe_ni,
  input logic        pad_i,
  input logic        pad_oe_o,
  input logic        fb_o
);
  // R12: preload wins over capture
  a_r12_preload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_en_i |=> q_w == $past(pre_val_i));

  // R6: normal capture of the sum
  a_r6_capture_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_en_i |=> q_w == $past(sum_w));

  // R6: registered driver follows the global enable
  a_r6_reg_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == MD_REG |-> pad_oe_o == !oe_ni);

  // R7: combinatorial output always drives
  a_r7_comb_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == MD_COMB |-> pad_oe_o);

  // R8: I/O driver follows the enable term
  a_r8_bidir_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == MD_BIDIR |-> (pad_oe_o == en_term_w) && (fb_o == pad_i));

  // R9: input mode never drives
  a_r9_input_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == MD_INPUT |-> !pad_oe_o && (fb_o == pad_i));

  // R10: registered feedback is the inverted state
  a_r10_reg_feedback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w == MD_REG |-> fb_o == !q_w);

  // R11: register clear during reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_reset_zero: assert (q_w == 1'b0);
    end
  end
endmodule

bind sop_slice sop_slice_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_w    (mode_w),
  .sum_w     (sum_w),
  .en_term_w (en_term_w),
  .q_w       (q_w),
  .pre_en_i  (pre_en_i),
  .pre_val_i (pre_val_i),
  .oe_ni     (oe_ni),
  .pad_i     (pad_i),
  .pad_oe_o  (pad_oe_o),
  .fb_o      (fb_o)
);

// File: tb/sim_sop_slice.sv
module sim_sop_slice;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NTR = 8;
  localparam int NA = NE + 1;
  localparam int FWB = (NTR + 1) * 2 * NA;

  // {in[3:0], expected sum} for f = (in0 & ~in1) | (in2 & in3)
  localparam logic [4:0] VEC [10] = '{
    5'b0000_0, 5'b0001_1, 5'b0011_0, 5'b1100_1, 5'b1000_0,
    5'b0100_0, 5'b1101_1, 5'b1111_1, 5'b0010_0, 5'b1001_1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] in_v = '0;
  logic [FWB-1:0] fuse = '0;
  logic ga = 1'b0, gb = 1'b1, lc = 1'b0;
  logic pol = 1'b1, oe_n = 1'b0, pre_en = 1'b0, pre_val = 1'b0, pad_in = 1'b0;
  logic pad_out, pad_oe, fb;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_slice #(.N_EXT(NE), .N_TERM(NTR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .fuse_i(fuse),
    .cfg_simple_i(ga), .cfg_regfam_i(gb), .cfg_local_i(lc),
    .pol_i(pol), .oe_ni(oe_n), .pre_en_i(pre_en), .pre_val_i(pre_val),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .fb_o(fb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // connect literal of input k in term t; comp selects the inverse
  task automatic connect(input int t, input int k, input bit comp);
    fuse[t*2*NA + 2*k + (comp ? 1 : 0)] = 1'b1;
  endtask

  // make every term 0..NTR-1 contradictory on input 0
  task automatic all_data_off();
    for (int t = 0; t < NTR; t++) begin
      connect(t, 0, 0);
      connect(t, 0, 1);
    end
  endtask

  task automatic load_f();
    fuse = '0;
    all_data_off();
    fuse[0 +: 2*NA] = '0;
    fuse[2*NA +: 2*NA] = '0;
    connect(0, 0, 0); connect(0, 1, 1);
    connect(1, 2, 0); connect(1, 3, 0);
    connect(NTR, 3, 0);
  endtask

  task automatic set_mode(input logic a, input logic b, input logic c);
    ga = a; gb = b; lc = c;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    load_f();
    // R11: reset state in registered mode
    set_mode(0, 1, 0); pol = 1; oe_n = 0;
    repeat (2) @(posedge clk);
    #1 check("R11 reset pin pol1", pad_out, 1'b0);
    pol = 0; #1 check("R11 reset pin pol0", pad_out, 1'b1);
    check("R10 reset feedback", fb, 1'b1);
    @(negedge clk); rst_n = 1; pol = 1;

    // R3 R7: table in combinatorial output mode, both polarities
    set_mode(1, 0, 0);
    foreach (VEC[i]) begin
      @(negedge clk);
      in_v = VEC[i][4:1]; pol = 1;
      #1 check("R3 R7 table pol1", pad_out, VEC[i][0]);
      check("R7 comb drives", pad_oe, 1'b1);
      pol = 0;
      #1 check("R7 table pol0", pad_out, ~VEC[i][0]);
    end
    pol = 1;

    // R5: mode bit A high ignores bit B
    set_mode(1, 1, 0); in_v = 4'b0001;
    #1 check("R5 1x0 comb", pad_out, 1'b1);
    check("R5 1x0 drives", pad_oe, 1'b1);

    // R1: empty term
    @(negedge clk);
    fuse = '0; all_data_off(); fuse[3*2*NA +: 2*NA] = '0;
    in_v = 4'b0110;
    #1 check("R1 empty term high", pad_out, 1'b1);

    // R2: contradiction on every term
    fuse = '0; all_data_off();
    for (int v = 0; v < 16; v++) begin
      in_v = v[3:0];
      #1 check("R2 contradictory low", pad_out, 1'b0);
    end

    // R4: empty enable term does not enter the sum
    set_mode(0, 1, 1); in_v = 4'b1111;
    #1 check("R4 enable term excluded", pad_out, 1'b0);
    check("R4 enable term drives", pad_oe, 1'b1);

    // R8: combinatorial I/O
    load_f(); set_mode(0, 1, 1);
    in_v = 4'b0111; pad_in = 1;
    #1 check("R8 oe off en term 0", pad_oe, 1'b0);
    check("R8 feedback pin 1", fb, 1'b1);
    in_v = 4'b1000; pad_in = 0;
    #1 check("R8 oe on en term 1", pad_oe, 1'b1);
    check("R8 feedback pin 0", fb, 1'b0);
    // R5: 00x also selects I/O
    set_mode(0, 0, 0);
    #1 check("R5 00x bidir", pad_oe, 1'b1);
    in_v = 4'b0000;
    #1 check("R5 00x bidir off", pad_oe, 1'b0);

    // R9: dedicated input
    set_mode(1, 0, 1); in_v = 4'b1000; pad_in = 1;
    #1 check("R9 never drives", pad_oe, 1'b0);
    check("R9 feedback pin 1", fb, 1'b1);
    pad_in = 0;
    #1 check("R9 feedback pin 0", fb, 1'b0);

    // R6: registered capture
    load_f(); set_mode(0, 1, 0); oe_n = 0;
    @(negedge clk); in_v = 4'b0001;
    @(posedge clk); #1 check("R6 capture 1", pad_out, 1'b1);
    check("R10 feedback inverted", fb, 1'b0);
    in_v = 4'b0000;
    #1 check("R6 holds between edges", pad_out, 1'b1);
    oe_n = 1;
    #1 check("R6 oe_n high off", pad_oe, 1'b0);
    oe_n = 0;
    #1 check("R6 oe_n low on", pad_oe, 1'b1);
    @(posedge clk); #1 check("R6 capture 0", pad_out, 1'b0);
    check("R10 feedback 1", fb, 1'b1);
    pol = 0;
    #1 check("R6 inverted polarity", pad_out, 1'b1);
    pol = 1;

    // R10: term built on the feedback literal toggles register
    @(negedge clk);
    fuse = '0; all_data_off();
    fuse[0 +: 2*NA] = '0; connect(0, NE, 0);
    @(posedge clk); #1 check("R10 toggle to 1", pad_out, 1'b1);
    @(posedge clk); #1 check("R10 toggle to 0", pad_out, 1'b0);

    // R12: preload priority
    @(negedge clk);
    load_f(); in_v = 4'b0001; pre_en = 1; pre_val = 0;
    @(posedge clk); #1 check("R12 preload 0 over sum 1", pad_out, 1'b0);
    @(negedge clk); in_v = 4'b0000; pre_val = 1;
    @(posedge clk); #1 check("R12 preload 1 over sum 0", pad_out, 1'b1);
    @(negedge clk); pre_en = 0;
    @(posedge clk); #1 check("R12 capture resumes", pad_out, 1'b0);

    // R11: reset during operation
    @(negedge clk); pre_en = 1; pre_val = 1;
    @(posedge clk); @(negedge clk); pre_en = 0;
    rst_n = 0;
    #1 check("R11 async clear", pad_out, 1'b0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule